// File: doc/BRIEF.md
# Seconds Counter with Two Alarm Comparators

This block is a register-mapped real-time clock core. A 32-bit seconds count advances by one each time a one-cycle tick strobe arrives, and it wraps to zero after its maximum value. Two compare registers each hold a target time. When a tick moves the count onto a target, that alarm's flag in a sticky status register is set. Each alarm has its own interrupt configuration word. Its enable bit gates the flag onto a dedicated interrupt pin, and a shared pin carries the OR of both.

Software reaches the block over a simple 32-bit bus. The bus uses a write strobe, a byte address and write data, and the read data follows the address combinationally. Two registers are stored and read back only. A clock-correction word holds a step-size mode bit and a 14-bit magnitude whose top bit is inverted, so 0x2000 means nominal timing. A configuration/test byte whose low eight bits, when nonzero, tell software that the clock must be initialised.

Top module: `rtc_core`

## Requirements
- R1: After reset the time, both compare registers, the status register and both interrupt configuration registers read 0. The correction register reads 0x2000, the config/test register reads the parameter TEST_INIT (default 0x01), and all three interrupt outputs are low.
- R2: The time register (byte offset 0x0C) increases by exactly one on each cycle with tick_i high, and it holds its value on cycles without a tick.
- R3: A bus write to the time register in the same cycle as a tick loads the written value, and no increment happens in that cycle.
- R4: A tick at time 0xFFFFFFFF makes the time 0x00000000.
- R5: On a tick whose incremented time equals compare register 1 (offset 0x10) or compare register 2 (offset 0x14), status bit 0 or bit 1 respectively (offset 0x00) is set. The bit then stays set on later ticks.
- R6: Writing the status register clears each bit whose write-data bit is 1 and leaves bits written with 0 unchanged. If a clear and a new match happen in the same cycle, the bit ends up set.
- R7: The interrupt configuration registers at 0x04 (alarm 1) and 0x08 (alarm 2) keep write-data bits [2:0]: bit 0 is alarm enable, bit 1 is periodic enable and bit 2 is the 1 Hz select. Bits [31:3] read 0.
- R8: alarm1_irq_o is high exactly when status bit 0 and the alarm-enable bit of 0x04 are both set. alarm2_irq_o is the same for status bit 1 and 0x08, and irq_o is high when either is high.
- R9: The correction register at 0x18 keeps write-data bit 15 (mode) and bits [13:0] (magnitude, bit 13 inverted). Bit 14 and bits [31:16] read 0.
- R10: The config/test register at 0x1C keeps write-data bits [7:0], and bits [31:8] read 0.
- R11: Addresses whose word index is above 7, or whose two low bits are nonzero, read 0, and writes to them change no register.
- R12: An alarm flag is set only by a tick. Writing a compare register equal to the current time, or writing the time equal to a compare value, does not set it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-second strobe, one cycle wide |
| wr_en_i | input | 1 | Bus write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| alarm1_irq_o | output | 1 | Alarm 1 interrupt |
| alarm2_irq_o | output | 1 | Alarm 2 interrupt |
| irq_o | output | 1 | OR of both alarm interrupts |

## Verification
A wrong count shows on the time register on the read just after the tick that caused it. A wrong compare or flag update shows at once on the interrupt pins when the alarm is enabled, and on the status readback one cycle after the tick otherwise. The corner cases that hide faults are the ones where two events meet in one cycle. These are a time write with a tick, a status clear with a new match, and the wrap from the maximum count onto a compare value of zero, so the stimulus drives each of them on purpose. Masking of reserved bits and the decoding of unmapped and unaligned addresses show up directly on rdata_o.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;
    localparam int DATA_W     = 32;
    localparam int NUM_ALARMS = 2;
    localparam int NUM_REGS   = 8;
    localparam int IRQ_CFG_W  = 3;

    // word indices (byte offset / 4)
    localparam int IDX_STATUS = 0;
    localparam int IDX_CFG1   = 1;
    localparam int IDX_TIME   = 3;
    localparam int IDX_ALM1   = 4;
    localparam int IDX_CORR   = 6;
    localparam int IDX_TEST   = 7;

    localparam logic [15:0] CORR_NOMINAL = 16'h2000;

    typedef struct packed {
        logic [15:0] corr;
        logic [7:0]  test;
    } misc_regs_t;
endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] time_o,
    output logic [W-1:0] next_time_o,
    output logic         step_o
);
    typedef struct packed {
        logic [W-1:0] secs;
    } cnt_t;

    cnt_t         st_d, st_q;
    logic [W-1:0] incr;

    always_comb begin
        st_d = st_q;
        incr = st_q.secs + W'(1);
        if (load_i) begin
            st_d.secs = load_val_i;
        end else if (tick_i) begin
            st_d.secs = incr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign time_o      = st_q.secs;
    assign next_time_o = incr;
    assign step_o      = tick_i & ~load_i;
endmodule

// File: rtl/rtc_alarm_slot.sv
module rtc_alarm_slot #(
    parameter int W     = 32,
    parameter int CFG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_wr_i,
    input  logic             cfg_wr_i,
    input  logic [W-1:0]     wdata_i,
    input  logic             flag_clr_i,
    input  logic             step_i,
    input  logic [W-1:0]     next_time_i,
    output logic [W-1:0]     cmp_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic             flag_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [W-1:0]     cmp;
        logic [CFG_W-1:0] cfg;
        logic             flag;
    } slot_t;

    slot_t st_d, st_q;
    logic  hit;

    always_comb begin
        st_d = st_q;
        hit  = step_i && (next_time_i == st_q.cmp);
        if (cmp_wr_i) st_d.cmp = wdata_i;
        if (cfg_wr_i) st_d.cfg = wdata_i[CFG_W-1:0];
        if (flag_clr_i) st_d.flag = 1'b0;
        if (hit)        st_d.flag = 1'b1;   // a new match outranks a clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp_o  = st_q.cmp;
    assign cfg_o  = st_q.cfg;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & st_q.cfg[0];
endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
    import rtc_core_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic                    valid_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [NUM_ALARMS-1:0]   flags_i,
    input  logic [IRQ_CFG_W-1:0]    cfg1_i,
    input  logic [IRQ_CFG_W-1:0]    cfg2_i,
    input  logic [DATA_W-1:0]       time_i,
    input  logic [DATA_W-1:0]       cmp1_i,
    input  logic [DATA_W-1:0]       cmp2_i,
    input  misc_regs_t              misc_i,
    output logic [DATA_W-1:0]       rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (valid_i) begin
            case (idx_i)
                IDX_W'(0): rdata_o = DATA_W'(flags_i);
                IDX_W'(1): rdata_o = DATA_W'(cfg1_i);
                IDX_W'(2): rdata_o = DATA_W'(cfg2_i);
                IDX_W'(3): rdata_o = time_i;
                IDX_W'(4): rdata_o = cmp1_i;
                IDX_W'(5): rdata_o = cmp2_i;
                IDX_W'(6): rdata_o = DATA_W'(misc_i.corr);
                IDX_W'(7): rdata_o = DATA_W'(misc_i.test);
                default:   rdata_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_core_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter logic [7:0]  TEST_INIT = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              alarm1_irq_o,
    output logic              alarm2_irq_o,
    output logic              irq_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]     word_idx;
    logic                 aligned;
    logic [NUM_REGS-1:0]  wr_sel;

    assign word_idx = addr_i[ADDR_W-1:2];
    assign aligned  = (addr_i[1:0] == 2'b00);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
        assign wr_sel[i] = wr_en_i && aligned && (word_idx == IDX_W'(i));
    end

    // seconds counter
    logic [DATA_W-1:0] time_now, time_next;
    logic              step;

    rtc_time_counter #(.W(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (wr_sel[IDX_TIME]),
        .load_val_i (wdata_i),
        .time_o     (time_now),
        .next_time_o(time_next),
        .step_o     (step)
    );

    // alarm slots
    logic [DATA_W-1:0]    cmp_val   [NUM_ALARMS];
    logic [IRQ_CFG_W-1:0] cfg_val   [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] alarm_flag;
    logic [NUM_ALARMS-1:0] alarm_irq;

    for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_alarm
        rtc_alarm_slot #(.W(DATA_W), .CFG_W(IRQ_CFG_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmp_wr_i   (wr_sel[IDX_ALM1 + k]),
            .cfg_wr_i   (wr_sel[IDX_CFG1 + k]),
            .wdata_i    (wdata_i),
            .flag_clr_i (wr_sel[IDX_STATUS] & wdata_i[k]),
            .step_i     (step),
            .next_time_i(time_next),
            .cmp_o      (cmp_val[k]),
            .cfg_o      (cfg_val[k]),
            .flag_o     (alarm_flag[k]),
            .irq_o      (alarm_irq[k])
        );
    end

    // stored-only registers
    misc_regs_t misc_d, misc_q;

    always_comb begin
        misc_d = misc_q;
        if (wr_sel[IDX_CORR]) misc_d.corr = {wdata_i[15], 1'b0, wdata_i[13:0]};
        if (wr_sel[IDX_TEST]) misc_d.test = wdata_i[7:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            misc_q.corr <= CORR_NOMINAL;
            misc_q.test <= TEST_INIT;
        end else begin
            misc_q <= misc_d;
        end
    end

    rtc_read_mux #(.IDX_W(IDX_W)) u_rd (
        .valid_i(aligned),
        .idx_i  (word_idx),
        .flags_i(alarm_flag),
        .cfg1_i (cfg_val[0]),
        .cfg2_i (cfg_val[1]),
        .time_i (time_now),
        .cmp1_i (cmp_val[0]),
        .cmp2_i (cmp_val[1]),
        .misc_i (misc_q),
        .rdata_o(rdata_o)
    );

    assign alarm1_irq_o = alarm_irq[0];
    assign alarm2_irq_o = alarm_irq[1];
    assign irq_o        = |alarm_irq;
endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [31:0]       wdata_i,
    input logic [31:0]       rdata_o,
    input logic [31:0]       time_q,
    input logic [31:0]       cmp1,
    input logic [31:0]       cmp2,
    input logic [1:0]        flags,
    input logic              irq_o
);
    logic time_wr, stat_wr, corr_rd;
    assign time_wr = wr_en_i && (addr_i == ADDR_W'(12));
    assign stat_wr = wr_en_i && (addr_i == ADDR_W'(0));
    assign corr_rd = (addr_i == ADDR_W'(24));

    a_r2_tick_increments: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !time_wr |=> time_q == $past(time_q) + 32'd1);

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !time_wr |=> $stable(time_q));

    a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr |=> time_q == $past(wdata_i));

    a_r5_match1_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !time_wr && (time_q + 32'd1 == cmp1) |=> flags[0]);

    a_r5_match2_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !time_wr && (time_q + 32'd1 == cmp2) |=> flags[1]);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flags[0] && !(stat_wr && wdata_i[0]) |=> flags[0]);

    a_r12_flag_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !$rose(flags[0]) && !$rose(flags[1]));

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flags != 2'b00);

    a_r9_corr_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        corr_rd |-> rdata_o[31:16] == 16'h0 && !rdata_o[14]);
endmodule

bind rtc_core rtc_core_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .time_q (time_now),
    .cmp1   (cmp_val[0]),
    .cmp2   (cmp_val[1]),
    .flags  (alarm_flag),
    .irq_o  (irq_o)
);

// File: tb/rtc_core_bench.sv
module rtc_core_bench;
    localparam int ADDR_W = 6;

    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2, OP_WT = 2'd3;
    localparam logic [5:0] A_STAT = 6'h00, A_CFG1 = 6'h04, A_CFG2 = 6'h08, A_TIME = 6'h0C,
                           A_ALM1 = 6'h10, A_ALM2 = 6'h14, A_CORR = 6'h18, A_TEST = 6'h1C;

    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, A_STAT, 32'h0, 32'h0000_0000, 8'd1},   // R1
        '{OP_RD, A_CORR, 32'h0, 32'h0000_2000, 8'd1},   // R1
        '{OP_RD, A_TEST, 32'h0, 32'h0000_0001, 8'd1},   // R1
        '{OP_RD, A_TIME, 32'h0, 32'h0000_0000, 8'd1},   // R1
        '{OP_TK, A_STAT, 32'h0, 32'h0, 8'd2},
        '{OP_TK, A_STAT, 32'h0, 32'h0, 8'd2},
        '{OP_RD, A_TIME, 32'h0, 32'h0000_0002, 8'd2},   // R2
        '{OP_WR, A_TIME, 32'h100, 32'h0, 8'd3},
        '{OP_RD, A_TIME, 32'h0, 32'h0000_0100, 8'd3},   // R3
        '{OP_WR, A_ALM1, 32'h102, 32'h0, 8'd5},
        '{OP_TK, A_STAT, 32'h0, 32'h0, 8'd5},
        '{OP_RD, A_STAT, 32'h0, 32'h0000_0000, 8'd5},   // R5 not yet
        '{OP_TK, A_STAT, 32'h0, 32'h0, 8'd5},
        '{OP_RD, A_STAT, 32'h0, 32'h0000_0001, 8'd5},   // R5 match
        '{OP_TK, A_STAT, 32'h0, 32'h0, 8'd5},
        '{OP_RD, A_STAT, 32'h0, 32'h0000_0001, 8'd5},   // R5 sticky
        '{OP_WR, A_STAT, 32'h0, 32'h0, 8'd6},
        '{OP_RD, A_STAT, 32'h0, 32'h0000_0001, 8'd6},   // R6 zero keeps
        '{OP_WR, A_STAT, 32'h1, 32'h0, 8'd6},
        '{OP_RD, A_STAT, 32'h0, 32'h0000_0000, 8'd6},   // R6 clear
        '{OP_WT, A_TIME, 32'h55, 32'h0, 8'd3},
        '{OP_RD, A_TIME, 32'h0, 32'h0000_0055, 8'd3},   // R3 write beats tick
        '{OP_WR, A_CFG1, 32'hFFFF_FFFF, 32'h0, 8'd7},
        '{OP_RD, A_CFG1, 32'h0, 32'h0000_0007, 8'd7},   // R7
        '{OP_WR, A_CFG2, 32'h5, 32'h0, 8'd7},
        '{OP_RD, A_CFG2, 32'h0, 32'h0000_0005, 8'd7},   // R7
        '{OP_WR, A_CORR, 32'hFFFF_FFFF, 32'h0, 8'd9},
        '{OP_RD, A_CORR, 32'h0, 32'h0000_BFFF, 8'd9},   // R9
        '{OP_WR, A_TEST, 32'h1234, 32'h0, 8'd10},
        '{OP_RD, A_TEST, 32'h0, 32'h0000_0034, 8'd10},  // R10
        '{OP_WR, 6'h20, 32'hDEAD, 32'h0, 8'd11},
        '{OP_WR, 6'h0D, 32'hBEEF, 32'h0, 8'd11},
        '{OP_RD, 6'h20, 32'h0, 32'h0000_0000, 8'd11},   // R11
        '{OP_RD, 6'h0D, 32'h0, 32'h0000_0000, 8'd11},   // R11 unaligned
        '{OP_RD, A_TIME, 32'h0, 32'h0000_0055, 8'd11},  // R11 no side effect
        '{OP_WR, A_TIME, 32'hFFFF_FFFF, 32'h0, 8'd4},
        '{OP_TK, A_STAT, 32'h0, 32'h0, 8'd4},
        '{OP_RD, A_TIME, 32'h0, 32'h0000_0000, 8'd4},   // R4 wrap
        '{OP_RD, A_STAT, 32'h0, 32'h0000_0002, 8'd5}    // R5 alarm 2 at 0 on wrap
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_i = 1'b0;
    logic              wr_en_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [31:0]       wdata_i = '0;
    logic [31:0]       rdata_o;
    logic              alarm1_irq_o, alarm2_irq_o, irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    rtc_core u_rtc_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .alarm1_irq_o(alarm1_irq_o), .alarm2_irq_o(alarm2_irq_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr_i  = a;
        wdata_i = d;
        wr_en_i = (op == OP_WR) || (op == OP_WT);
        tick_i  = (op == OP_TK) || (op == OP_WT);
        @(posedge clk);
        #1;
        wr_en_i = 1'b0;
        tick_i  = 1'b0;
    endtask

    task automatic rd_check(input logic [5:0] a, input string req, input logic [31:0] exp);
        @(negedge clk);
        addr_i = a;
        #1;
        check(req, rdata_o, exp);
    endtask

    task automatic pins_check(input string req, input logic [2:0] exp);
        @(negedge clk);
        #1;
        check(req, {29'h0, alarm1_irq_o, alarm2_irq_o, irq_o}, {29'h0, exp});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        pins_check("R1 irq pins after reset", 3'b000);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].op == OP_RD)
                rd_check(VEC[i].addr, $sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].exp);
            else
                apply(VEC[i].op, VEC[i].addr, VEC[i].data);
        end

        // R8: flag1 set, cfg2 enable set, flag0 clear with cfg1 enable set
        pins_check("R8 alarm2 irq", 3'b011);
        apply(OP_WR, A_STAT, 32'h2);
        pins_check("R8 irq drops after clear", 3'b000);

        // R12: writes that make time equal an alarm do not flag
        apply(OP_WR, A_ALM1, 32'h0);
        apply(OP_WR, A_TIME, 32'h200);
        apply(OP_WR, A_ALM1, 32'h200);
        rd_check(A_STAT, "R12 compare write", 32'h0);
        apply(OP_WR, A_ALM2, 32'h300);
        apply(OP_WR, A_TIME, 32'h300);
        rd_check(A_STAT, "R12 time write", 32'h0);

        // R6: clear and new match in one cycle, set wins
        apply(OP_WR, A_TIME, 32'h10);
        apply(OP_WR, A_ALM1, 32'h11);
        apply(OP_TK, A_STAT, 32'h0);
        rd_check(A_STAT, "R5 flag before collision", 32'h1);
        pins_check("R8 alarm1 irq", 3'b101);
        apply(OP_WR, A_ALM1, 32'h12);
        apply(OP_WT, A_STAT, 32'h1);
        rd_check(A_STAT, "R6 set beats clear", 32'h1);
        rd_check(A_TIME, "R2 tick during status write", 32'h12);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        rd_check(A_TIME, "R1 time after reset", 32'h0);
        rd_check(A_CORR, "R1 corr after reset", 32'h2000);
        rd_check(A_ALM1, "R1 compare after reset", 32'h0);
        rd_check(A_CFG1, "R1 cfg after reset", 32'h0);
        pins_check("R1 irq pins after second reset", 3'b000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule